// File: doc/BRIEF.md
# Processor Bus Cycle Classifier

This block watches the control strobes of an 8-bit processor that has a 16-bit address bus. It never drives the bus. On every clock it samples the six active-low strobes (machine-cycle-one, memory request, I/O request, read, write and refresh). It decodes them into one of eight cycle types and reports that type on a 3-bit output. A one-clock pulse marks each point where a new non-idle strobe pattern first appears.

The type comes from specific pairings of strobes, not from read or write alone. Machine-cycle-one with memory request is an opcode fetch. Machine-cycle-one with I/O request is an interrupt acknowledge. Refresh with memory request is a DRAM refresh. On every non-idle cycle the monitor captures the address and data buses. On refresh cycles it also holds the 7-bit row address, and on I/O cycles it holds the 8-bit port number.

Strobe combinations that the processor never produces set a sticky error flag. Two saturating 16-bit counters tally fetch cycles and refresh cycles. All outputs are registered and appear one clock after the strobes are sampled.

Top module: `busCycleMon`

## Requirements
- R1: While reset (rstN low) is applied and on the first sample after it, cycType is 0, cycStart is 0, protoErr is 0, and capAddr, capData, rowAddr, portAddr, fetchCnt and rfshCnt are all 0.
- R2: When machine-cycle-one and memory request are both active and the pattern is legal, cycType becomes 1 (fetch) after the next rising edge, whether or not read is also active.
- R3: Machine-cycle-one with I/O request gives cycType 6 (interrupt acknowledge), and capData takes the vector present on the data bus.
- R4: Memory request with refresh and without machine-cycle-one gives cycType 7. rowAddr takes address bits 6..0 and is unchanged on every other cycle type.
- R5: Memory request with read gives cycType 2, and memory request with write gives cycType 3. In both cases capAddr and capData take the bus values.
- R6: I/O request with read gives cycType 4, and I/O request with write gives cycType 5. portAddr takes address bits 7..0 and is unchanged on every other cycle type.
- R7: Any legal pattern not covered by R2 to R6 gives cycType 0 (idle). On an idle cycle capAddr, capData, rowAddr and portAddr keep their values.
- R8: Read with write, memory request with I/O request, or machine-cycle-one with refresh is illegal. An illegal pattern reports cycType 0, captures nothing and sets protoErr. protoErr then stays 1 until reset.
- R9: cycStart is 1 for exactly the sample whose active-strobe pattern differs from the previous sample's pattern and decodes to a non-idle type. Otherwise it is 0.
- R10: fetchCnt increments on each sample where cycStart rises with type 1, and rfshCnt does the same for type 7. Both stop at 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Synchronous reset, active low |
| m1N | input | 1 | Machine-cycle-one strobe, active low |
| mreqN | input | 1 | Memory request strobe, active low |
| iorqN | input | 1 | I/O request strobe, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| rfshN | input | 1 | Refresh strobe, active low |
| addr | input | 16 | Address bus |
| data | input | 8 | Data bus |
| cycType | output | 3 | 0 idle, 1 fetch, 2 mem read, 3 mem write, 4 I/O read, 5 I/O write, 6 int ack, 7 refresh |
| cycStart | output | 1 | One-sample pulse when a new non-idle pattern appears |
| protoErr | output | 1 | Sticky illegal-pattern flag |
| capAddr | output | 16 | Address from the last non-idle cycle |
| capData | output | 8 | Data from the last non-idle cycle |
| rowAddr | output | 7 | Row address from the last refresh cycle |
| portAddr | output | 8 | Port number from the last I/O read or write |
| fetchCnt | output | 16 | Saturating count of fetch cycle starts |
| rfshCnt | output | 16 | Saturating count of refresh cycle starts |

## Verification
A bad stored previous pattern shows up as a missing or extra cycStart pulse. Because the counters are gated by that pulse, it also shows up as a fetchCnt or rfshCnt that drifts from the expected tally. Both effects are visible one clock after the faulty sample. A capture register with the wrong enable shows up on capAddr, rowAddr or portAddr at the first idle or unrelated cycle that follows. A wrong saturation limit appears only once the counter reaches 65535, so fetches are driven back to back until it does.

// File: rtl/busmon_pkg.sv
package busmon_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE  = 3'd0,
    CYC_FETCH = 3'd1,
    CYC_MRD   = 3'd2,
    CYC_MWR   = 3'd3,
    CYC_IORD  = 3'd4,
    CYC_IOWR  = 3'd5,
    CYC_INTA  = 3'd6,
    CYC_RFSH  = 3'd7
  } cyc_e;

  // strobes from control to datapath, valid in the sampling cycle
  typedef struct packed {
    logic capAll;
    logic capRow;
    logic capPort;
    logic incFetch;
    logic incRfsh;
  } ctlStrb_t;

  // bit positions inside the active-high strobe pattern
  localparam int PAT_W  = 6;
  localparam int B_M1   = 5;
  localparam int B_MREQ = 4;
  localparam int B_IORQ = 3;
  localparam int B_RD   = 2;
  localparam int B_WR   = 1;
  localparam int B_RFSH = 0;

endpackage

// File: rtl/busmon_ctrl.sv
module busmon_ctrl
  import busmon_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [PAT_W-1:0] patIn,
  output cyc_e             cycType,
  output logic             cycStart,
  output logic             protoErr,
  output ctlStrb_t         strb
);

  logic             m1, mreq, iorq, rd, wr, rfsh;
  logic             illegal;
  logic             newStart;
  cyc_e             nextType;
  logic [PAT_W-1:0] prevPat;

  assign m1   = patIn[B_M1];
  assign mreq = patIn[B_MREQ];
  assign iorq = patIn[B_IORQ];
  assign rd   = patIn[B_RD];
  assign wr   = patIn[B_WR];
  assign rfsh = patIn[B_RFSH];

  assign illegal = (rd & wr) | (mreq & iorq) | (m1 & rfsh);

  always_comb begin
    nextType = CYC_IDLE;
    if (!illegal) begin
      if (m1 & mreq)        nextType = CYC_FETCH;
      else if (m1 & iorq)   nextType = CYC_INTA;
      else if (mreq & rfsh) nextType = CYC_RFSH;
      else if (mreq & rd)   nextType = CYC_MRD;
      else if (mreq & wr)   nextType = CYC_MWR;
      else if (iorq & rd)   nextType = CYC_IORD;
      else if (iorq & wr)   nextType = CYC_IOWR;
      else                  nextType = CYC_IDLE;
    end
  end

  assign newStart = (patIn != prevPat) && (nextType != CYC_IDLE);

  always_comb begin
    strb.capAll   = (nextType != CYC_IDLE);
    strb.capRow   = (nextType == CYC_RFSH);
    strb.capPort  = (nextType == CYC_IORD) || (nextType == CYC_IOWR);
    strb.incFetch = newStart && (nextType == CYC_FETCH);
    strb.incRfsh  = newStart && (nextType == CYC_RFSH);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevPat  <= '0;
      cycType  <= CYC_IDLE;
      cycStart <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      prevPat  <= patIn;
      cycType  <= nextType;
      cycStart <= newStart;
      if (illegal) protoErr <= 1'b1;
    end
  end

  AST_START_NONIDLE: assert property (@(posedge clk) disable iff (!rstN)
    cycStart |-> (cycType != CYC_IDLE)); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr); // R8

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protoErr) |-> (cycType == CYC_IDLE)); // R8

  AST_REPEAT_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (patIn == prevPat) |=> !cycStart); // R9

endmodule

// File: rtl/busmon_dp.sv
module busmon_dp
  import busmon_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  parameter int ROW_W  = 7,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [ADDR_W-1:0] capAddr,
  output logic [DATA_W-1:0] capData,
  output logic [ROW_W-1:0]  rowAddr,
  output logic [PORT_W-1:0] portAddr,
  output logic [CNT_W-1:0]  fetchCnt,
  output logic [CNT_W-1:0]  rfshCnt
);

  localparam int NUM_CNT = 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [NUM_CNT-1:0] incVec;
  logic [CNT_W-1:0]   cntQ [NUM_CNT];

  assign incVec = {strb.incRfsh, strb.incFetch};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capAddr  <= '0;
      capData  <= '0;
      rowAddr  <= '0;
      portAddr <= '0;
    end else begin
      if (strb.capAll) begin
        capAddr <= addr;
        capData <= data;
      end
      if (strb.capRow)  rowAddr  <= addr[ROW_W-1:0];
      if (strb.capPort) portAddr <= addr[PORT_W-1:0];
    end
  end

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rstN)                               cntQ[gi] <= '0;
      else if (incVec[gi] && cntQ[gi] != CNT_MAX) cntQ[gi] <= cntQ[gi] + CNT_ONE;
    end

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rstN)
      (cntQ[gi] == CNT_MAX) |=> (cntQ[gi] == CNT_MAX)); // R10

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
      ##1 ((cntQ[gi] == $past(cntQ[gi])) ||
           (cntQ[gi] == $past(cntQ[gi]) + CNT_ONE))); // R10
  end

  assign fetchCnt = cntQ[0];
  assign rfshCnt  = cntQ[1];

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capRow |=> $stable(rowAddr)); // R4

  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capPort |=> $stable(portAddr)); // R6

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capAll |=> ($stable(capAddr) && $stable(capData))); // R7

endmodule

// File: rtl/busCycleMon.sv
module busCycleMon
  import busmon_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  parameter int ROW_W  = 7,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              m1N,
  input  logic              mreqN,
  input  logic              iorqN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              rfshN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [2:0]        cycType,
  output logic              cycStart,
  output logic              protoErr,
  output logic [ADDR_W-1:0] capAddr,
  output logic [DATA_W-1:0] capData,
  output logic [ROW_W-1:0]  rowAddr,
  output logic [PORT_W-1:0] portAddr,
  output logic [CNT_W-1:0]  fetchCnt,
  output logic [CNT_W-1:0]  rfshCnt
);

  logic [PAT_W-1:0] pat;
  cyc_e             typeQ;
  ctlStrb_t         strb;

  assign pat = ~{m1N, mreqN, iorqN, rdN, wrN, rfshN};

  busmon_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .patIn    (pat),
    .cycType  (typeQ),
    .cycStart (cycStart),
    .protoErr (protoErr),
    .strb     (strb)
  );

  busmon_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .ROW_W  (ROW_W),
    .PORT_W (PORT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .addr     (addr),
    .data     (data),
    .capAddr  (capAddr),
    .capData  (capData),
    .rowAddr  (rowAddr),
    .portAddr (portAddr),
    .fetchCnt (fetchCnt),
    .rfshCnt  (rfshCnt)
  );

  assign cycType = typeQ;

endmodule

// File: tb/busCycleMon_tb_top.sv
module busCycleMon_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        m1N = 1'b1, mreqN = 1'b1, iorqN = 1'b1, rdN = 1'b1, wrN = 1'b1, rfshN = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic [2:0]  cycType;
  logic        cycStart, protoErr;
  logic [15:0] capAddr, fetchCnt, rfshCnt;
  logic [7:0]  capData, portAddr;
  logic [6:0]  rowAddr;

  int checks = 0;
  int fails  = 0;

  // expected model
  logic [5:0]  mPrev;
  logic [2:0]  mType;
  logic        mStart, mErr;
  logic [15:0] mAddr, mFetch, mRfsh;
  logic [7:0]  mData, mPort;
  logic [6:0]  mRow;

  always #4 clk = ~clk;

  busCycleMon dut_i (
    .clk(clk), .rstN(rstN), .m1N(m1N), .mreqN(mreqN), .iorqN(iorqN),
    .rdN(rdN), .wrN(wrN), .rfshN(rfshN), .addr(addr), .data(data),
    .cycType(cycType), .cycStart(cycStart), .protoErr(protoErr),
    .capAddr(capAddr), .capData(capData), .rowAddr(rowAddr),
    .portAddr(portAddr), .fetchCnt(fetchCnt), .rfshCnt(rfshCnt)
  );

  // pattern bits: 5 m1, 4 mreq, 3 iorq, 2 rd, 1 wr, 0 refresh (active high)
  function automatic logic isIllegal(input logic [5:0] p);
    return (p[2] && p[1]) || (p[4] && p[3]) || (p[5] && p[0]);
  endfunction

  function automatic logic [2:0] expType(input logic [5:0] p);
    if (isIllegal(p))      return 3'd0;
    if (p[5] && p[4])      return 3'd1;
    if (p[5] && p[3])      return 3'd6;
    if (p[4] && p[0])      return 3'd7;
    if (p[4] && p[2])      return 3'd2;
    if (p[4] && p[1])      return 3'd3;
    if (p[3] && p[2])      return 3'd4;
    if (p[3] && p[1])      return 3'd5;
    return 3'd0;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    check(req, "cycType",  32'(cycType),  32'(mType));
    check(req, "cycStart", 32'(cycStart), 32'(mStart));
    check(req, "protoErr", 32'(protoErr), 32'(mErr));
    check(req, "capAddr",  32'(capAddr),  32'(mAddr));
    check(req, "capData",  32'(capData),  32'(mData));
    check(req, "rowAddr",  32'(rowAddr),  32'(mRow));
    check(req, "portAddr", 32'(portAddr), 32'(mPort));
    check(req, "fetchCnt", 32'(fetchCnt), 32'(mFetch));
    check(req, "rfshCnt",  32'(rfshCnt),  32'(mRfsh));
  endtask

  task automatic modelReset();
    mPrev = '0; mType = '0; mStart = 0; mErr = 0;
    mAddr = '0; mData = '0; mRow = '0; mPort = '0; mFetch = '0; mRfsh = '0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    {m1N, mreqN, iorqN, rdN, wrN, rfshN} = 6'h3F;
    repeat (3) @(negedge clk);
    modelReset();
    checkAll("R1");
    rstN = 1;
  endtask

  // called at a negedge: drive, clock, update model, check at following negedge
  task automatic step(input logic [5:0] p, input logic [15:0] a, input logic [7:0] d,
                      input bit doChk, input string req);
    logic [2:0] t;
    logic       st;
    {m1N, mreqN, iorqN, rdN, wrN, rfshN} = ~p;
    addr = a;
    data = d;
    @(posedge clk);
    t  = expType(p);
    st = (p != mPrev) && (t != 3'd0);
    if (isIllegal(p)) mErr = 1;
    mPrev = p; mType = t; mStart = st;
    if (t != 3'd0) begin mAddr = a; mData = d; end
    if (t == 3'd7) mRow = a[6:0];
    if (t == 3'd4 || t == 3'd5) mPort = a[7:0];
    if (st && t == 3'd1 && mFetch != 16'hFFFF) mFetch = mFetch + 1;
    if (st && t == 3'd7 && mRfsh != 16'hFFFF) mRfsh = mRfsh + 1;
    @(negedge clk);
    if (doChk) checkAll(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [5:0] rp;
    void'($urandom(32'd20240611));
    modelReset();
    doReset();
    // R2 fetch with and without read
    step(6'b110000, 16'h1234, 8'h3E, 1, "R2");
    step(6'b110100, 16'h1234, 8'h3E, 1, "R2");
    // R7 idle holds captures
    step(6'b000000, 16'hFFFF, 8'hAA, 1, "R7");
    step(6'b010000, 16'hEEEE, 8'hBB, 1, "R7");
    // R4 refresh
    step(6'b010001, 16'h80F3, 8'h11, 1, "R4");
    step(6'b000000, 16'h0000, 8'h00, 1, "R4");
    // R5 memory read and write
    step(6'b010100, 16'hC000, 8'h5A, 1, "R5");
    step(6'b010010, 16'hC001, 8'hA5, 1, "R5");
    // R6 I/O read and write
    step(6'b001100, 16'h124F, 8'h77, 1, "R6");
    step(6'b001010, 16'h3420, 8'h88, 1, "R6");
    step(6'b010100, 16'h5555, 8'h01, 1, "R6");
    // R3 interrupt acknowledge vector
    step(6'b101000, 16'h0042, 8'hFF, 1, "R3");
    // R9 held pattern gives no second start
    step(6'b101000, 16'h0042, 8'hFF, 1, "R9");
    step(6'b010010, 16'h0100, 8'h02, 1, "R9");
    step(6'b010010, 16'h0101, 8'h03, 1, "R9");
    // random legal traffic
    for (int i = 0; i < 400; i++) begin
      do rp = 6'($urandom); while (isIllegal(rp));
      step(rp, 16'($urandom), 8'($urandom), 1, "R9");
    end
    // R8 illegal patterns and stickiness
    step(6'b000110, 16'h9999, 8'h99, 1, "R8");
    step(6'b000000, 16'h0000, 8'h00, 1, "R8");
    step(6'b011000, 16'h7777, 8'h66, 1, "R8");
    step(6'b010100, 16'h2222, 8'h33, 1, "R8");
    doReset();
    // R10 saturation of the fetch counter
    for (int i = 0; i < 65540; i++)
      step((i % 2 == 0) ? 6'b110000 : 6'b110100, 16'(i), 8'(i), 0, "R10");
    step(6'b000000, 16'h0000, 8'h00, 1, "R10");
    step(6'b110000, 16'h0001, 8'h01, 1, "R10");
    for (int i = 0; i < 5; i++) begin
      step(6'b010001, 16'(i * 3), 8'h00, 1, "R10");
      step(6'b000000, 16'h0000, 8'h00, 1, "R10");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule